// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 17-bit three-state buses, called the A side and the B side. Each direction has its own storage and its own control pins. The A-to-B direction reads the A bus and can drive the B bus. The B-to-A direction reads the B bus and can drive the A bus. Each direction runs in one of three modes, selected by its latch-enable and chip-enable pins:

- **Transparent:** the input is passed straight through.
- **Latched:** the last value is held.
- **Clocked:** the input is captured on a rising edge of that direction's clock.

Every output driver is active-low enabled. When its enable is high, the driver releases the bus.

All storage sits in one core clock domain. The latch enables, chip enables and direction clocks are plain inputs sampled on the rising edge of the core clock `clk`. A rising edge of a direction clock is detected by comparing it with the value it had at the previous core edge. While a latch enable is high, its storage reloads on every core edge, so the value it holds afterwards is the last one seen before the enable fell.

The block also forwards two clocks unchanged: the A-to-B clock toward the B side, and a clock arriving from the B side toward the A side. It raises a contention flag whenever both output enables are low at the same time.

Top module: `ubt_xcvr`

## Requirements
- R1: The data path is W bits wide (default 17) in each direction, and every bit from 0 to W-1 is carried independently.
- R2: While `le_ab` is 1, the value driven on `b_io` equals the value on `a_io` in the same cycle, whatever `ce_ab_n` and `clk_ab` are.
- R3: While `le_ab` is 1, the A-to-B storage reloads from `a_io` at every rising edge of `clk`. After `le_ab` falls, `b_io` shows the `a_io` value seen at the last edge with `le_ab` at 1.
- R4: The A-to-B storage captures `a_io` at a rising edge of `clk` when three conditions hold: `le_ab` is 0, `ce_ab_n` is 0, and `clk_ab` is 1 at that edge after being 0 at the previous edge. The new value appears on `b_io` after that edge.
- R5: With `le_ab` at 0 and no detected rising edge of `clk_ab`, the A-to-B storage and the driven value on `b_io` stay unchanged.
- R6: With `le_ab` at 0 and `ce_ab_n` at 1, rising edges of `clk_ab` are ignored and the storage keeps its value.
- R7: `oe_ab_n` at 0 makes the block drive `b_io`, and `oe_ba_n` at 0 makes it drive `a_io`. When an enable is 1, the block releases that bus to high impedance.
- R8: The B-to-A direction follows R2 to R6 using `le_ba`, `ce_ba_n` and `clk_ba`, with `b_io` as its input and `a_io` as its output.
- R9: `contention_o` is 1 exactly when `oe_ab_n` and `oe_ba_n` are both 0. Storage keeps updating normally while the flag is set.
- R10: `clk_fwd_o` follows `clk_ab` and `bclk_o` follows `bclk_i` with no register in the path.
- R11: When `rst_n` is 0, both storages are forced to zero at once, asynchronously, and the direction clock history is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all storage updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_io | inout | W | A-side bus |
| b_io | inout | W | B-side bus |
| oe_ab_n | input | 1 | Active-low drive enable for `b_io` |
| le_ab | input | 1 | A-to-B transparent select |
| ce_ab_n | input | 1 | Active-low A-to-B capture qualifier |
| clk_ab | input | 1 | A-to-B capture clock, sampled by `clk` |
| oe_ba_n | input | 1 | Active-low drive enable for `a_io` |
| le_ba | input | 1 | B-to-A transparent select |
| ce_ba_n | input | 1 | Active-low B-to-A capture qualifier |
| clk_ba | input | 1 | B-to-A capture clock, sampled by `clk` |
| bclk_i | input | 1 | Clock arriving from the B side |
| clk_fwd_o | output | 1 | Forwarded copy of `clk_ab` |
| bclk_o | output | 1 | Forwarded copy of `bclk_i` |
| contention_o | output | 1 | Both output enables active |

## Verification
The storage assertions assume three things about the inputs:

- The control pins and direction clocks change only between core edges.
- A direction clock stays at each level for at least one core cycle, so every edge of interest is seen as a level change between two samples.
- The two directions are never both transparent with both output drivers on, because that would close a combinational loop through the buses.

The stimulus respects all three. It changes every input a fixed delay after a core edge and holds it for the whole cycle. Its random patterns never enable both drivers at once. Contention is entered only in directed steps where both latch enables are low. The bench releases a bus whenever the block may drive it.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef struct packed {
    logic le;    // transparent select
    logic ce_n;  // active-low capture qualifier
    logic cap;   // direction clock, sampled
  } ubt_ctl_t;

endpackage

// File: rtl/ubt_edge.sv
module ubt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/ubt_path.sv
module ubt_path
  import ubt_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ubt_ctl_t     ctl,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] store_q;
  logic         rise;
  logic         load;

  ubt_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (ctl.cap),
    .rise_o (rise)
  );

  // transparent mode reloads each cycle; clocked mode needs a qualified edge
  assign load = ctl.le | (~ctl.ce_n & rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    store_q <= '0;
    else if (load) store_q <= d_i;
  end

  assign q_o = ctl.le ? d_i : store_q;

  AST_TRANSPARENT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.le |=> store_q == $past(d_i)); // R3

  AST_CLOCKED_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && !ctl.ce_n && rise) |=> store_q == $past(d_i)); // R4

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && !rise) |=> $stable(store_q)); // R5

  AST_CE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && ctl.ce_n) |=> $stable(store_q)); // R6

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         oe_ab_n,
  input  logic         le_ab,
  input  logic         ce_ab_n,
  input  logic         clk_ab,
  input  logic         oe_ba_n,
  input  logic         le_ba,
  input  logic         ce_ba_n,
  input  logic         clk_ba,
  input  logic         bclk_i,
  output logic         clk_fwd_o,
  output logic         bclk_o,
  output logic         contention_o
);

  localparam int NDIR = 2;

  ubt_ctl_t           ctl  [NDIR];
  logic     [W-1:0]   din  [NDIR];
  logic     [W-1:0]   dout [NDIR];

  // index 0: A to B, index 1: B to A
  assign ctl[0] = '{le: le_ab, ce_n: ce_ab_n, cap: clk_ab};
  assign ctl[1] = '{le: le_ba, ce_n: ce_ba_n, cap: clk_ba};
  assign din[0] = a_io;
  assign din[1] = b_io;

  for (genvar gd = 0; gd < NDIR; gd++) begin : g_dir
    ubt_path #(.W(W)) u_path (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl[gd]),
      .d_i   (din[gd]),
      .q_o   (dout[gd])
    );
  end

  assign b_io = oe_ab_n ? {W{1'bz}} : dout[0];
  assign a_io = oe_ba_n ? {W{1'bz}} : dout[1];

  assign contention_o = ~oe_ab_n & ~oe_ba_n;
  assign clk_fwd_o    = clk_ab;
  assign bclk_o       = bclk_i;

endmodule

// File: tb/test_ubt_xcvr.sv
`timescale 1ns/100ps
module test_ubt_xcvr;

  localparam int W = 17;

  logic clk = 1'b0;
  logic rst_n;
  logic oe_ab_n, le_ab, ce_ab_n, clk_ab;
  logic oe_ba_n, le_ba, ce_ba_n, clk_ba;
  logic bclk_i;
  logic clk_fwd_o, bclk_o, contention_o;
  logic a_en, b_en;
  logic [W-1:0] a_drv, b_drv;
  wire  [W-1:0] a_io, b_io;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] m_ab, m_ba;
  logic p_ab, p_ba;

  always #2 clk = ~clk;

  assign a_io = a_en ? a_drv : {W{1'bz}};
  assign b_io = b_en ? b_drv : {W{1'bz}};

  for (genvar i = 0; i < W; i++) begin : g_pull
    pullup (a_io[i]);
    pullup (b_io[i]);
  end

  ubt_xcvr #(.W(W)) i_ubt_xcvr (
    .clk(clk), .rst_n(rst_n), .a_io(a_io), .b_io(b_io),
    .oe_ab_n(oe_ab_n), .le_ab(le_ab), .ce_ab_n(ce_ab_n), .clk_ab(clk_ab),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .ce_ba_n(ce_ba_n), .clk_ba(clk_ba),
    .bclk_i(bclk_i), .clk_fwd_o(clk_fwd_o), .bclk_o(bclk_o),
    .contention_o(contention_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one core cycle: check outputs mid-cycle, then advance the model at the edge
  task automatic step(input string tag);
    logic [W-1:0] av, bv, ao, bo;
    string ta, tb;
    #1;
    if (!rst_n) begin m_ab = '0; m_ba = '0; p_ab = 0; p_ba = 0; end
    if (!oe_ba_n && oe_ab_n) begin
      bv = b_en ? b_drv : '1;
      ao = le_ba ? bv : m_ba;
      av = ao;
    end else begin
      av = a_en ? a_drv : (!oe_ba_n ? m_ba : '1);
      bo = le_ab ? av : m_ab;
      bv = b_en ? b_drv : (!oe_ab_n ? bo : '1);
    end
    tb = (tag != "") ? tag : (oe_ab_n ? "R7" : (le_ab ? "R2" : "R5"));
    ta = (tag != "") ? tag : (oe_ba_n ? "R7" : "R8");
    chk(tb, b_io, bv);
    chk(ta, a_io, av);
    chk("R9", W'(contention_o), W'(!oe_ab_n && !oe_ba_n));
    chk("R10", W'({bclk_o, clk_fwd_o}), W'({bclk_i, clk_ab}));
    @(posedge clk);
    if (!rst_n) begin m_ab = '0; m_ba = '0; end
    else begin
      if (le_ab || (!ce_ab_n && clk_ab && !p_ab)) m_ab = av;
      if (le_ba || (!ce_ba_n && clk_ba && !p_ba)) m_ba = bv;
    end
    p_ab = rst_n ? clk_ab : 1'b0;
    p_ba = rst_n ? clk_ba : 1'b0;
    #1;
  endtask

  task automatic idle();
    oe_ab_n = 0; oe_ba_n = 1; le_ab = 0; le_ba = 0;
    ce_ab_n = 1; ce_ba_n = 1; clk_ab = 0; clk_ba = 0;
    a_en = 1; b_en = 0; a_drv = '0; b_drv = '0; bclk_i = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4127);
    m_ab = '0; m_ba = '0; p_ab = 0; p_ba = 0;
    idle();
    rst_n = 0;
    @(posedge clk); #1;
    // R11: reset clears both storages; both outputs on, latches closed
    a_en = 0; oe_ba_n = 0;
    step("R11");
    step("R11");
    rst_n = 1; idle();
    step("");
    // R1: end bits pass through transparently
    le_ab = 1; a_drv = 17'h10001; step("R1");
    // R3: hold last transparent value after latch enable falls
    a_drv = 17'h0A5A5; step("R3");
    le_ab = 0; a_drv = 17'h1FFF0; step("R3");
    step("R3");
    // R4: qualified rising edge captures
    ce_ab_n = 0; clk_ab = 0; a_drv = 17'h12345; step("R3");
    clk_ab = 1; step("R4");
    a_drv = 17'h05555; step("R4");
    clk_ab = 0; step("R4");
    // R6: edge ignored when chip enable inactive
    ce_ab_n = 1; a_drv = 17'h0F0F0; step("R6");
    clk_ab = 1; step("R6");
    a_drv = 17'h00001; step("R6");
    // R2: transparent regardless of chip enable
    le_ab = 1; a_drv = 17'h1ABCD; step("R2");
    le_ab = 0; clk_ab = 0; step("R5");
    // R8: B-to-A clocked capture and transparency
    oe_ab_n = 1; oe_ba_n = 0; a_en = 0; b_en = 1;
    b_drv = 17'h13579; le_ba = 1; step("R8");
    le_ba = 0; ce_ba_n = 0; b_drv = 17'h02468; step("R8");
    clk_ba = 1; step("R8");
    b_drv = 17'h1EEEE; clk_ba = 0; step("R8");
    ce_ba_n = 1; clk_ba = 1; step("R8");
    step("R8");
    // R7: both drivers off, bus released to pull level
    oe_ba_n = 1; b_en = 0; clk_ba = 0; step("R7");
    // R9: contention with storage still capturing
    oe_ab_n = 0; oe_ba_n = 0; le_ab = 0; le_ba = 0; step("R9");
    ce_ab_n = 0; clk_ab = 1; step("R9");
    step("R9");
    ce_ab_n = 1; clk_ab = 0; oe_ba_n = 1; step("");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] r;
      r = 16'($urandom);
      oe_ab_n = r[0]; oe_ba_n = r[1];
      if (!oe_ab_n && !oe_ba_n) oe_ba_n = 1;
      le_ab = r[2] & r[3]; le_ba = r[4] & r[5];
      ce_ab_n = r[6]; ce_ba_n = r[7];
      clk_ab = r[8]; clk_ba = r[9]; bclk_i = r[10];
      a_en = oe_ba_n & r[11]; b_en = oe_ab_n & r[12];
      a_drv = W'($urandom); b_drv = W'($urandom);
      if (r[15:13] == 3'd0) begin
        rst_n = 0; step("R11"); rst_n = 1;
      end else step("");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule